// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block lives inside the register file of a 16550-style UART. Five interrupt sources feed it: receiver line errors, a receive character timeout, received data ready, transmitter holding register empty, and modem status changes. Each source is qualified by its interrupt-enable bit. The highest-priority qualified source is turned into a 4-bit identification code, and a single interrupt request line is raised whenever any source wins.

The FIFO-enable state is shown in the upper two bits of the identification byte. The block holds one piece of state of its own: the transmitter-empty pending flag. That flag is set when the holding register becomes empty or when its enable bit is switched on while the register is empty. It is dropped when software reads the identification byte while that code is shown, when the enable is switched off, or when the holding register fills again. The identification byte and the request line are combinational. The pending flag moves on the clock edge that follows a strobe.

Top module: `uart_irq_prio`

## Requirements
- R1: While reset is asserted and directly after it, with no source active, the identification byte reads 0x01 and `irq` is low.
- R2: When several qualified sources are active, the code shown is the highest one in this order: line status, then character timeout, then received data, then transmitter empty, then modem status.
- R3: The code in bits 3:0 is 0x6 for line status, 0xC for character timeout, 0x4 for received data, 0x2 for transmitter empty, 0x0 for modem status and 0x1 when nothing is pending.
- R4: A line-status interrupt is qualified when enable bit 2 (`ier[2]`) is 1 and any of the four `lsr_err` bits (overrun, parity, framing, break) is 1. Data ready and holding-register-empty never raise it.
- R5: A character timeout is qualified only when `rx_timeout` is 1 and the received-data enable `ier[0]` is 1.
- R6: A received-data interrupt is qualified when `ier[0]` and `lsr_dr` are 1, and either `fifo_en` is 0 or `rx_count` is at least `rx_trig`.
- R7: A read strobe on the identification byte in a cycle where it shows code 0x2 clears the transmitter-empty pending flag from the next cycle on.
- R8: An enable write that changes `ier[1]` from 0 to 1 while `lsr_thre` is 1 sets the pending flag, even after an earlier read cleared it. A write that changes `ier[1]` to 0 clears the flag. The flag is visible from the next cycle.
- R9: Bits 7:6 of the identification byte equal 2'b11 when `fifo_en` is 1 and 2'b00 otherwise. Bits 5:4 are 0.
- R10: `irq` is 1 exactly when the code in bits 3:0 is not 0x1.
- R11: A 0-to-1 change of `lsr_thre` sets the pending flag, and `lsr_thre` at 0 clears it, each from the next cycle, unless an enable write changes `ier[1]` in the same cycle.
- R12: A modem-status interrupt is qualified when `ier[3]` is 1 and any `msr_delta` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier | input | 4 | Current interrupt-enable register: bit0 received data, bit1 tx empty, bit2 line status, bit3 modem status |
| ier_wr | input | 1 | Strobe: the enable register is written this cycle |
| ier_wdata | input | 4 | Value being written to the enable register |
| iir_rd | input | 1 | Strobe: the identification byte is read this cycle |
| lsr_dr | input | 1 | Receive data ready |
| lsr_err | input | 4 | Overrun, parity, framing and break status |
| lsr_thre | input | 1 | Transmit holding register empty |
| rx_timeout | input | 1 | Receive character timeout pending |
| fifo_en | input | 1 | FIFOs enabled |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| msr_delta | input | 4 | Modem status change bits |
| iir | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The code, the FIFO flag bits and `irq` are combinational in the inputs and the pending flag. They are due in the same cycle as the stimulus. The bench drives on the falling edge and compares 1 ns later, before the next rising edge. Effects of `iir_rd`, `ier_wr` and `lsr_thre` changes on the pending flag appear only after the next rising edge. So the reference model updates its own pending flag in the same place, and the bench checks in the following cycle that the code has changed. Each cycle of every scenario is compared against the model, including the strobe cycle itself, where the old code must still be shown.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int NUM_SRC = 5;

   // source index order is the priority order, 0 highest
   localparam int SRC_LINE = 0;
   localparam int SRC_TMO  = 1;
   localparam int SRC_RXD  = 2;
   localparam int SRC_THR  = 3;
   localparam int SRC_MDM  = 4;

   typedef enum logic [3:0] {
      IID_MDM  = 4'h0,
      IID_NONE = 4'h1,
      IID_THR  = 4'h2,
      IID_RXD  = 4'h4,
      IID_LINE = 4'h6,
      IID_TMO  = 4'hC
   } iid_e;

   function automatic iid_e src_code(input int idx);
      case (idx)
         SRC_LINE: return IID_LINE;
         SRC_TMO:  return IID_TMO;
         SRC_RXD:  return IID_RXD;
         SRC_THR:  return IID_THR;
         SRC_MDM:  return IID_MDM;
         default:  return IID_NONE;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
   import uart_irq_pkg::*;
#(
   parameter int CNT_W     = 5,
   parameter bit TMO_GATED = 1'b1
) (
   input  logic [3:0]         ier,
   input  logic               lsr_dr,
   input  logic [3:0]         lsr_err,
   input  logic               rx_timeout,
   input  logic               fifo_en,
   input  logic [CNT_W-1:0]   rx_count,
   input  logic [CNT_W-1:0]   rx_trig,
   input  logic               thr_pend,
   input  logic [3:0]         msr_delta,
   output logic [NUM_SRC-1:0] req
);

   logic at_trigger;
   assign at_trigger = (rx_count >= rx_trig);

   assign req[SRC_LINE] = ier[2] & (|lsr_err);
   assign req[SRC_RXD]  = ier[0] & lsr_dr & (~fifo_en | at_trigger);
   assign req[SRC_THR]  = ier[1] & thr_pend;
   assign req[SRC_MDM]  = ier[3] & (|msr_delta);

   generate
      if (TMO_GATED) begin : g_tmo_gated
         assign req[SRC_TMO] = ier[0] & rx_timeout;
      end else begin : g_tmo_free
         assign req[SRC_TMO] = rx_timeout;
      end
   endgenerate

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
   input  logic clk,
   input  logic rst_n,
   input  logic thre,
   input  logic ier_thri,
   input  logic ier_wr,
   input  logic ier_wdata_thri,
   input  logic iir_rd,
   input  logic thr_shown,
   output logic pend
);

   logic thre_q;
   logic pend_q;
   logic pend_d;
   logic en_change;

   assign en_change = ier_wr & (ier_wdata_thri ^ ier_thri);

   always_comb begin
      if (en_change)
         pend_d = ier_wdata_thri & thre;
      else if (!thre)
         pend_d = 1'b0;
      else if (iir_rd && thr_shown)
         pend_d = 1'b0;
      else if (!thre_q)
         pend_d = 1'b1;
      else
         pend_d = pend_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thre_q <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         thre_q <= thre;
         pend_q <= pend_d;
      end
   end

   assign pend = pend_q;

   // R7: reading the tx-empty code drops the flag
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && thr_shown && !en_change) |=> !pend_q);

   // R8: enable rising with holding register empty re-arms
   a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_wr && !ier_thri && ier_wdata_thri && thre) |=> pend_q);

   // R8: enable falling drops the flag
   a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_wr && ier_thri && !ier_wdata_thri) |=> !pend_q);

   // R11: holding register full drops the flag
   a_r11_thre_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!thre && !en_change) |=> !pend_q);

endmodule

// File: rtl/uart_irq_enc.sv
module uart_irq_enc
   import uart_irq_pkg::*;
#(
   parameter int N = NUM_SRC
) (
   input  logic [N-1:0] req,
   output logic [3:0]   code,
   output logic         active
);

   logic [N:0]   taken;
   logic [N-1:0] sel;

   assign taken[0] = 1'b0;

   generate
      for (genvar g = 0; g < N; g++) begin : g_rank
         assign sel[g]     = req[g] & ~taken[g];
         assign taken[g+1] = taken[g] | req[g];
      end
   endgenerate

   always_comb begin
      code = IID_NONE;
      for (int i = 0; i < N; i++) begin
         if (sel[i]) code = src_code(i);
      end
   end

   assign active = taken[N];

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int  FIFO_DEPTH = 16,
   parameter bit  TMO_GATED  = 1'b1,
   localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       ier,
   input  logic             ier_wr,
   input  logic [3:0]       ier_wdata,
   input  logic             iir_rd,
   input  logic             lsr_dr,
   input  logic [3:0]       lsr_err,
   input  logic             lsr_thre,
   input  logic             rx_timeout,
   input  logic             fifo_en,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] rx_trig,
   input  logic [3:0]       msr_delta,
   output logic [7:0]       iir,
   output logic             irq
);

   generate
      if (FIFO_DEPTH < 1 || FIFO_DEPTH > 256) begin : g_bad_depth
         $error("uart_irq_prio: FIFO_DEPTH out of range");
      end
   endgenerate

   logic [NUM_SRC-1:0] req;
   logic [3:0]         code;
   logic               active;
   logic               thr_pend;
   logic               thr_shown;

   assign thr_shown = (code == IID_THR);

   uart_irq_src #(
      .CNT_W     (CNT_W),
      .TMO_GATED (TMO_GATED)
   ) i_src (
      .ier        (ier),
      .lsr_dr     (lsr_dr),
      .lsr_err    (lsr_err),
      .rx_timeout (rx_timeout),
      .fifo_en    (fifo_en),
      .rx_count   (rx_count),
      .rx_trig    (rx_trig),
      .thr_pend   (thr_pend),
      .msr_delta  (msr_delta),
      .req        (req)
   );

   uart_irq_thre i_thre (
      .clk            (clk),
      .rst_n          (rst_n),
      .thre           (lsr_thre),
      .ier_thri       (ier[1]),
      .ier_wr         (ier_wr),
      .ier_wdata_thri (ier_wdata[1]),
      .iir_rd         (iir_rd),
      .thr_shown      (thr_shown),
      .pend           (thr_pend)
   );

   uart_irq_enc #(
      .N (NUM_SRC)
   ) i_enc (
      .req    (req),
      .code   (code),
      .active (active)
   );

   assign iir = {fifo_en, fifo_en, 2'b00, code};
   assign irq = active;

   // R10: request line follows the code
   a_r10_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (iir[3:0] != IID_NONE));

   // R9: FIFO flag bits
   a_r9_fifo_flag: assert property (@(posedge clk) disable iff (!rst_n)
      iir[7:4] == {fifo_en, fifo_en, 2'b00});

   // R4 and R2: a qualified line error always wins
   a_r4_line_status: assert property (@(posedge clk) disable iff (!rst_n)
      (ier[2] && (|lsr_err)) |-> (iir[3:0] == IID_LINE));

   generate
      if (TMO_GATED) begin : g_tmo_chk
         // R5: timeout masked by the received-data enable
         a_r5_tmo_masked: assert property (@(posedge clk) disable iff (!rst_n)
            !ier[0] |-> (iir[3:0] != IID_TMO));
      end
   endgenerate

endmodule

// File: tb/test_uart_irq_prio.sv
`timescale 1ns/1ps
module test_uart_irq_prio;

   localparam int FD = 16;
   localparam int CW = $clog2(FD + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    ier = '0;
   logic          ier_wr = 1'b0;
   logic [3:0]    ier_wdata = '0;
   logic          iir_rd = 1'b0;
   logic          lsr_dr = 1'b0;
   logic [3:0]    lsr_err = '0;
   logic          lsr_thre = 1'b1;
   logic          rx_timeout = 1'b0;
   logic          fifo_en = 1'b0;
   logic [CW-1:0] rx_count = '0;
   logic [CW-1:0] rx_trig = '0;
   logic [3:0]    msr_delta = '0;
   logic [7:0]    iir;
   logic          irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic m_pend = 1'b0;
   logic m_thre_prev = 1'b1;

   always #2.5 clk = ~clk;

   uart_irq_prio #(.FIFO_DEPTH(FD)) i_uart_irq_prio (
      .clk(clk), .rst_n(rst_n), .ier(ier), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
      .iir_rd(iir_rd), .lsr_dr(lsr_dr), .lsr_err(lsr_err), .lsr_thre(lsr_thre),
      .rx_timeout(rx_timeout), .fifo_en(fifo_en), .rx_count(rx_count),
      .rx_trig(rx_trig), .msr_delta(msr_delta), .iir(iir), .irq(irq)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         errors++;
         $display("FAIL watchdog: run did not end");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [3:0] model_code();
      if (ier[2] && lsr_err != 4'h0)                           return 4'h6;
      if (ier[0] && rx_timeout)                                return 4'hC;
      if (ier[0] && lsr_dr && (!fifo_en || rx_count >= rx_trig)) return 4'h4;
      if (ier[1] && m_pend)                                    return 4'h2;
      if (ier[3] && msr_delta != 4'h0)                         return 4'h0;
      return 4'h1;
   endfunction

   // called at a falling edge with the inputs already set
   task automatic step(input string tag);
      logic [3:0] c;
      logic [7:0] e;
      logic       ei;
      #1;
      c  = model_code();
      e  = {fifo_en, fifo_en, 2'b00, c};
      ei = (c != 4'h1);
      checks++;
      if (iir !== e || irq !== ei) begin
         errors++;
         $display("FAIL %s (R10 irq): iir=%h irq=%b expected iir=%h irq=%b",
                  tag, iir, irq, e, ei);
      end
      @(posedge clk);
      @(negedge clk);
      if (!rst_n) begin
         m_pend = 1'b0;
         m_thre_prev = 1'b1;
      end else begin
         if (ier_wr && ier_wdata[1] != ier[1]) m_pend = ier_wdata[1] && lsr_thre;
         else if (!lsr_thre)                   m_pend = 1'b0;
         else if (iir_rd && c == 4'h2)         m_pend = 1'b0;
         else if (!m_thre_prev)                m_pend = 1'b1;
         m_thre_prev = lsr_thre;
         if (ier_wr) ier = ier_wdata;
      end
      ier_wr = 1'b0;
      iir_rd = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      step("R1 during reset");
      step("R1 during reset");
      rst_n = 1'b1;
      step("R1 after reset");

      ier = 4'b0100;
      lsr_err = 4'b0001; step("R4 overrun");
      lsr_err = 4'b0010; step("R4 parity");
      lsr_err = 4'b0100; step("R4 framing");
      lsr_err = 4'b1000; step("R4 break");
      lsr_err = 4'b0000; lsr_dr = 1'b1; step("R4 data ready alone");
      lsr_dr = 1'b0;

      ier = 4'b0000; rx_timeout = 1'b1; step("R5 timeout masked");
      ier = 4'b0001; step("R5 timeout enabled");
      rx_timeout = 1'b0;

      fifo_en = 1'b1; lsr_dr = 1'b1; rx_trig = 8; rx_count = 7; step("R6 below trigger, R9");
      rx_count = 8;  step("R6 at trigger, R9");
      rx_count = 14; step("R6 above trigger");
      fifo_en = 1'b0; rx_count = 0; step("R6 no FIFO");
      lsr_dr = 1'b0; step("R6 no data");

      ier = 4'b1000; msr_delta = 4'b0100; step("R12 R3 modem delta");
      ier = 4'b0000; step("R12 modem masked");
      msr_delta = 4'b0000;

      ier_wr = 1'b1; ier_wdata = 4'b0010; step("R8 write cycle");
      step("R8 armed on enable");
      iir_rd = 1'b1; step("R7 read cycle");
      step("R7 cleared by read");
      ier_wr = 1'b1; ier_wdata = 4'b0000; step("R8 disable write");
      step("R8 disabled");
      ier_wr = 1'b1; ier_wdata = 4'b0010; step("R8 re-enable write");
      step("R8 re-armed after read");

      lsr_thre = 1'b0; step("R11 thre falls");
      step("R11 cleared by full");
      lsr_thre = 1'b1; step("R11 thre rises");
      step("R11 set by empty");

      ier = 4'b1111; fifo_en = 1'b1; rx_trig = 4; rx_count = 4;
      lsr_err = 4'b0010; rx_timeout = 1'b1; lsr_dr = 1'b1; msr_delta = 4'b0001;
      step("R2 all sources, R9");
      lsr_err = 4'b0000; step("R2 timeout next");
      rx_timeout = 1'b0; step("R2 data next");
      lsr_dr = 1'b0; step("R2 tx empty next");
      iir_rd = 1'b1; step("R2 read tx empty");
      step("R2 modem last");
      msr_delta = 4'b0000; step("R2 R3 none left");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule